// File: doc/BRIEF.md
# Performance-Level Configuration Selector

This block sits between the committed configuration of a clock root and the divider datapath that follows it. It holds a bank of eight preloaded configuration sets, one per performance level. Each set carries a half-integer divider code, a source select, a counter mode, and an M and N value. When level switching is enabled, the set chosen by a level index drives the divider datapath. When it is disabled, the committed configuration of the root passes straight through.

Software loads the per-level sets through a simple register port. A consumer changes the active level by writing the control register. Because every set is already in place, a level change needs no update request or acknowledge. The new configuration is presented on the clock edge that captures the write.

The N value is stored in complemented form and is decoded as the masked inverse of N plus M. A per-level divider code of zero is presented as a code of one.

Top module: `cm_dfs_selector`

## Requirements
- R1: After reset the control register reads 0, every per-level register reads 0, and level switching is disabled.
- R2: While switching is disabled, the outputs follow the committed inputs in the same cycle: divider = main_cfg bits HID_W-1:0 unchanged (including 0), source = main_cfg bits 10:8, mode = main_cfg bits 13:12, M = main_m masked to MND_W bits, N = (~main_n masked to MND_W bits) + M, modulo 2^MND_W.
- R3: While switching is enabled, the outputs come from the set of the applied level, and out_dfs_active is 1.
- R4: The per-level registers are mapped as follows: the configuration word for level l is at byte address 0x1C + 4·l, M is at 0x5C + 4·l, and N is at 0x9C + 4·l. A configuration word holds the divider at bits HID_W-1:0, the source at bits 10:8 and the mode at bits 13:12. A read returns only these bits, with all other bits reading 0. M and N read back masked to MND_W bits.
- R5: A per-level divider code of 0 is presented on out_div as 1. Nonzero codes are presented unchanged.
- R6: A per-level N is presented as (~N masked to MND_W bits) + M of the same level, modulo 2^MND_W.
- R7: A written level field of NUM_LEVELS or more is applied as level NUM_LEVELS-1.
- R8: The control register is at byte address 0x14. Bit 0 is the enable and bits 4:1 are the level. A read returns the enable in bit 0, the applied (clamped) level in bits 4:1, and 0 in all other bits.
- R9: A control write changes the outputs on the clock edge that captures it, and not before. No further handshake is needed.
- R10: Writes to addresses outside the map change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for both write and read |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for reg_addr, combinational |
| main_cfg | input | 32 | Committed configuration word of the root |
| main_m | input | 32 | Committed M value |
| main_n | input | 32 | Committed N value, complemented encoding |
| out_div | output | HID_W | Divider code to the datapath |
| out_src | output | 3 | Source select to the datapath |
| out_mode | output | 2 | Counter mode to the datapath |
| out_m | output | MND_W | M to the datapath |
| out_n | output | MND_W | Decoded N to the datapath |
| out_dfs_active | output | 1 | Level switching currently enabled |

## Verification
Several properties are checked on every cycle: the bypass of the source and mode fields while switching is disabled, a nonzero divider while switching is enabled, a clamped and zero-padded control readback, the enable following each control write, and stable outputs across cycles with no write while switching is enabled. Only the bench scenarios can show the address map and field masking, the exact per-level values with the N decode and the zero-divider remap, the clamping of every out-of-range level, the absence of any effect before the capturing edge, and the absence of any effect from unmapped writes. These depend on the loaded table contents, which the checker does not model.

// File: rtl/cm_dfs_pkg.sv
package cm_dfs_pkg;
  localparam int CTRL_OFS  = 'h14;
  localparam int CFG_BASE  = 'h1C;
  localparam int M_BASE    = 'h5C;
  localparam int N_BASE    = 'h9C;
  localparam int SRC_LSB   = 8;
  localparam int MODE_LSB  = 12;
  localparam int SRC_W     = 3;
  localparam int MODE_W    = 2;
  localparam int LVL_FLD_W = 4;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CTRL,
    RK_CFG,
    RK_M,
    RK_N
  } reg_kind_e;
endpackage

// File: rtl/cm_dfs_addr_dec.sv
module cm_dfs_addr_dec
  import cm_dfs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_LEVELS = 8,
  parameter int LVL_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [LVL_W-1:0]  idx
);
  localparam int SPAN = 4 * NUM_LEVELS;

  int a;

  always_comb begin
    a    = int'(addr);
    kind = RK_NONE;
    idx  = '0;
    if (a == CTRL_OFS) begin
      kind = RK_CTRL;
    end else if (addr[1:0] == 2'b00) begin
      if (a >= CFG_BASE && a < CFG_BASE + SPAN) begin
        kind = RK_CFG;
        idx  = LVL_W'((a - CFG_BASE) >> 2);
      end else if (a >= M_BASE && a < M_BASE + SPAN) begin
        kind = RK_M;
        idx  = LVL_W'((a - M_BASE) >> 2);
      end else if (a >= N_BASE && a < N_BASE + SPAN) begin
        kind = RK_N;
        idx  = LVL_W'((a - N_BASE) >> 2);
      end
    end
  end
endmodule

// File: rtl/cm_dfs_ctrl.sv
module cm_dfs_ctrl
  import cm_dfs_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int LVL_W      = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_kind_e            kind,
  input  logic [LVL_FLD_W:0]   wr_bits,
  output logic                 en_q,
  output logic [LVL_W-1:0]     lvl_q
);
  logic             ld;
  logic             en_d;
  logic [LVL_W-1:0] lvl_d;
  logic [LVL_FLD_W-1:0] fld;

  always_comb begin
    ld    = wr_en && (kind == RK_CTRL);
    fld   = wr_bits[LVL_FLD_W:1];
    en_d  = en_q;
    lvl_d = lvl_q;
    if (ld) begin
      en_d = wr_bits[0];
      if (int'(fld) >= NUM_LEVELS) lvl_d = LVL_W'(NUM_LEVELS - 1);
      else                         lvl_d = LVL_W'(fld);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      lvl_q <= '0;
    end else begin
      en_q  <= en_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/cm_dfs_level_bank.sv
module cm_dfs_level_bank
  import cm_dfs_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int LVL_W      = 3,
  parameter int HID_W      = 5,
  parameter int MND_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         kind,
  input  logic [LVL_W-1:0]  idx,
  input  logic [HID_W-1:0]  wr_div,
  input  logic [SRC_W-1:0]  wr_src,
  input  logic [MODE_W-1:0] wr_mode,
  input  logic [MND_W-1:0]  wr_mnd,
  output logic [HID_W-1:0]  div_o  [NUM_LEVELS],
  output logic [SRC_W-1:0]  src_o  [NUM_LEVELS],
  output logic [MODE_W-1:0] mode_o [NUM_LEVELS],
  output logic [MND_W-1:0]  m_o    [NUM_LEVELS],
  output logic [MND_W-1:0]  n_o    [NUM_LEVELS]
);
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    logic              hit, ld_cfg, ld_m, ld_n;
    logic [HID_W-1:0]  div_q, div_d;
    logic [SRC_W-1:0]  src_q, src_d;
    logic [MODE_W-1:0] mode_q, mode_d;
    logic [MND_W-1:0]  m_q, m_d, n_q, n_d;

    always_comb begin
      hit    = wr_en && (idx == LVL_W'(g));
      ld_cfg = hit && (kind == RK_CFG);
      ld_m   = hit && (kind == RK_M);
      ld_n   = hit && (kind == RK_N);
      div_d  = ld_cfg ? wr_div  : div_q;
      src_d  = ld_cfg ? wr_src  : src_q;
      mode_d = ld_cfg ? wr_mode : mode_q;
      m_d    = ld_m   ? wr_mnd  : m_q;
      n_d    = ld_n   ? wr_mnd  : n_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_q  <= '0;
        src_q  <= '0;
        mode_q <= '0;
        m_q    <= '0;
        n_q    <= '0;
      end else begin
        div_q  <= div_d;
        src_q  <= src_d;
        mode_q <= mode_d;
        m_q    <= m_d;
        n_q    <= n_d;
      end
    end

    assign div_o[g]  = div_q;
    assign src_o[g]  = src_q;
    assign mode_o[g] = mode_q;
    assign m_o[g]    = m_q;
    assign n_o[g]    = n_q;
  end
endmodule

// File: rtl/cm_dfs_select.sv
module cm_dfs_select
  import cm_dfs_pkg::*;
#(
  parameter int NUM_LEVELS = 8,
  parameter int LVL_W      = 3,
  parameter int HID_W      = 5,
  parameter int MND_W      = 8
) (
  input  logic              en,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [HID_W-1:0]  lv_div  [NUM_LEVELS],
  input  logic [SRC_W-1:0]  lv_src  [NUM_LEVELS],
  input  logic [MODE_W-1:0] lv_mode [NUM_LEVELS],
  input  logic [MND_W-1:0]  lv_m    [NUM_LEVELS],
  input  logic [MND_W-1:0]  lv_n    [NUM_LEVELS],
  input  logic [HID_W-1:0]  mn_div,
  input  logic [SRC_W-1:0]  mn_src,
  input  logic [MODE_W-1:0] mn_mode,
  input  logic [MND_W-1:0]  mn_m,
  input  logic [MND_W-1:0]  mn_n,
  output logic [HID_W-1:0]  o_div,
  output logic [SRC_W-1:0]  o_src,
  output logic [MODE_W-1:0] o_mode,
  output logic [MND_W-1:0]  o_m,
  output logic [MND_W-1:0]  o_n
);
  logic [MND_W-1:0] m_pick, n_pick;

  always_comb begin
    if (en) begin
      o_div  = (lv_div[lvl] == '0) ? HID_W'(1) : lv_div[lvl];
      o_src  = lv_src[lvl];
      o_mode = lv_mode[lvl];
      m_pick = lv_m[lvl];
      n_pick = lv_n[lvl];
    end else begin
      o_div  = mn_div;
      o_src  = mn_src;
      o_mode = mn_mode;
      m_pick = mn_m;
      n_pick = mn_n;
    end
    o_m = m_pick;
    o_n = (~n_pick) + m_pick;
  end
endmodule

// File: rtl/cm_dfs_selector.sv
module cm_dfs_selector
  import cm_dfs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_LEVELS = 8,
  parameter int HID_W      = 5,
  parameter int MND_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wr_data,
  output logic [31:0]       reg_rd_data,
  input  logic [31:0]       main_cfg,
  input  logic [31:0]       main_m,
  input  logic [31:0]       main_n,
  output logic [HID_W-1:0]  out_div,
  output logic [2:0]        out_src,
  output logic [1:0]        out_mode,
  output logic [MND_W-1:0]  out_m,
  output logic [MND_W-1:0]  out_n,
  output logic              out_dfs_active
);
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  reg_kind_e        kind;
  logic [LVL_W-1:0] idx;
  logic             en_q;
  logic [LVL_W-1:0] lvl_q;

  logic [HID_W-1:0]  lv_div  [NUM_LEVELS];
  logic [SRC_W-1:0]  lv_src  [NUM_LEVELS];
  logic [MODE_W-1:0] lv_mode [NUM_LEVELS];
  logic [MND_W-1:0]  lv_m    [NUM_LEVELS];
  logic [MND_W-1:0]  lv_n    [NUM_LEVELS];

  logic unused_bits;
  assign unused_bits = ^{reg_wr_data, main_cfg, main_m, main_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  cm_dfs_addr_dec #(.ADDR_W(ADDR_W), .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_dec (
    .addr (reg_addr),
    .kind (kind),
    .idx  (idx)
  );

  cm_dfs_ctrl #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (reg_wr_en),
    .kind    (kind),
    .wr_bits (reg_wr_data[LVL_FLD_W:0]),
    .en_q    (en_q),
    .lvl_q   (lvl_q)
  );

  cm_dfs_level_bank #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .HID_W(HID_W), .MND_W(MND_W)) u_bank (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .wr_en   (reg_wr_en),
    .kind    (kind),
    .idx     (idx),
    .wr_div  (reg_wr_data[HID_W-1:0]),
    .wr_src  (reg_wr_data[SRC_LSB +: SRC_W]),
    .wr_mode (reg_wr_data[MODE_LSB +: MODE_W]),
    .wr_mnd  (reg_wr_data[MND_W-1:0]),
    .div_o   (lv_div),
    .src_o   (lv_src),
    .mode_o  (lv_mode),
    .m_o     (lv_m),
    .n_o     (lv_n)
  );

  cm_dfs_select #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .HID_W(HID_W), .MND_W(MND_W)) u_sel (
    .en      (en_q),
    .lvl     (lvl_q),
    .lv_div  (lv_div),
    .lv_src  (lv_src),
    .lv_mode (lv_mode),
    .lv_m    (lv_m),
    .lv_n    (lv_n),
    .mn_div  (main_cfg[HID_W-1:0]),
    .mn_src  (main_cfg[SRC_LSB +: SRC_W]),
    .mn_mode (main_cfg[MODE_LSB +: MODE_W]),
    .mn_m    (main_m[MND_W-1:0]),
    .mn_n    (main_n[MND_W-1:0]),
    .o_div   (out_div),
    .o_src   (out_src),
    .o_mode  (out_mode),
    .o_m     (out_m),
    .o_n     (out_n)
  );

  assign out_dfs_active = en_q;

  always_comb begin
    reg_rd_data = '0;
    unique case (kind)
      RK_CTRL: begin
        reg_rd_data[0]             = en_q;
        reg_rd_data[LVL_FLD_W:1]   = LVL_FLD_W'(lvl_q);
      end
      RK_CFG: begin
        reg_rd_data[HID_W-1:0]            = lv_div[idx];
        reg_rd_data[SRC_LSB +: SRC_W]     = lv_src[idx];
        reg_rd_data[MODE_LSB +: MODE_W]   = lv_mode[idx];
      end
      RK_M:    reg_rd_data[MND_W-1:0] = lv_m[idx];
      RK_N:    reg_rd_data[MND_W-1:0] = lv_n[idx];
      default: reg_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cm_dfs_checker.sv
module cm_dfs_checker
  import cm_dfs_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_LEVELS = 8,
  parameter int HID_W      = 5,
  parameter int MND_W      = 8
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wr_data,
  input logic [31:0]       reg_rd_data,
  input logic [31:0]       main_cfg,
  input logic [HID_W-1:0]  out_div,
  input logic [2:0]        out_src,
  input logic [1:0]        out_mode,
  input logic [MND_W-1:0]  out_m,
  input logic [MND_W-1:0]  out_n,
  input logic              out_dfs_active
);
  logic ctrl_sel;
  assign ctrl_sel = (int'(reg_addr) == CTRL_OFS);

  // R2: bypass of source and mode while disabled
  a_r2_bypass_fields: assert property (@(posedge clk) disable iff (!core_rst_n)
    !out_dfs_active |-> (out_src == main_cfg[10:8] && out_mode == main_cfg[13:12]));

  // R5: a level-driven divider is never zero
  a_r5_div_nonzero: assert property (@(posedge clk) disable iff (!core_rst_n)
    out_dfs_active |-> (out_div != '0));

  // R7 and R8: control readback is clamped and zero-padded
  a_r7_ctrl_read_clamped: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctrl_sel |-> (int'(reg_rd_data[4:1]) < NUM_LEVELS && reg_rd_data[31:5] == '0));

  // R8: the enable follows the written bit 0
  a_r8_enable_follows_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    (reg_wr_en && ctrl_sel) |=> (out_dfs_active == $past(reg_wr_data[0])));

  // R9: with no write, an enabled selection holds
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    (out_dfs_active && !reg_wr_en) |=>
      (out_dfs_active && $stable(out_div) && $stable(out_src) && $stable(out_mode)
       && $stable(out_m) && $stable(out_n)));
endmodule

bind cm_dfs_selector cm_dfs_checker #(
  .ADDR_W(ADDR_W), .NUM_LEVELS(NUM_LEVELS), .HID_W(HID_W), .MND_W(MND_W)
) u_chk (
  .clk            (clk),
  .core_rst_n     (core_rst_n),
  .reg_wr_en      (reg_wr_en),
  .reg_addr       (reg_addr),
  .reg_wr_data    (reg_wr_data),
  .reg_rd_data    (reg_rd_data),
  .main_cfg       (main_cfg),
  .out_div        (out_div),
  .out_src        (out_src),
  .out_mode       (out_mode),
  .out_m          (out_m),
  .out_n          (out_n),
  .out_dfs_active (out_dfs_active)
);

// File: tb/tb_cm_dfs_selector.sv
module tb_cm_dfs_selector;
  localparam int ADDR_W = 8;
  localparam int NL     = 8;
  localparam int HID_W  = 5;
  localparam int MND_W  = 8;

  logic              clk;
  logic              rst_n;
  logic              reg_wr_en;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wr_data;
  logic [31:0]       reg_rd_data;
  logic [31:0]       main_cfg, main_m, main_n;
  logic [HID_W-1:0]  out_div;
  logic [2:0]        out_src;
  logic [1:0]        out_mode;
  logic [MND_W-1:0]  out_m, out_n;
  logic              out_dfs_active;

  int n_tests = 0;
  int n_fail  = 0;

  cm_dfs_selector #(.ADDR_W(ADDR_W), .NUM_LEVELS(NL), .HID_W(HID_W), .MND_W(MND_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .main_cfg(main_cfg), .main_m(main_m), .main_n(main_n),
    .out_div(out_div), .out_src(out_src), .out_mode(out_mode),
    .out_m(out_m), .out_n(out_n), .out_dfs_active(out_dfs_active)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // per-level stimulus, computed arithmetically
  function automatic logic [4:0] lv_div(int l); return 5'(l * 3); endfunction
  function automatic logic [2:0] lv_src(int l); return 3'(l + 5); endfunction
  function automatic logic [1:0] lv_mode(int l); return 2'(l); endfunction
  function automatic logic [7:0] lv_m(int l); return 8'(17 + l * 9); endfunction
  function automatic logic [7:0] lv_nwant(int l); return 8'(60 + l * 13); endfunction

  function automatic logic [25:0] exp_level(int l);
    logic [4:0] d;
    d = (lv_div(l) == 5'd0) ? 5'd1 : lv_div(l);
    return {d, lv_src(l), lv_mode(l), lv_m(l), lv_nwant(l)};
  endfunction

  function automatic logic [25:0] exp_main();
    logic [7:0] mm;
    mm = main_m[7:0];
    return {main_cfg[4:0], main_cfg[10:8], main_cfg[13:12], mm, 8'(~main_n[7:0] + mm)};
  endfunction

  function automatic logic [25:0] outs();
    return {out_div, out_src, out_mode, out_m, out_n};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_addr    = ADDR_W'(a);
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = ADDR_W'(a);
    #1;
    d = reg_rd_data;
  endtask

  function automatic logic [31:0] cfg_rb(int l);
    return 32'(lv_div(l)) | (32'(lv_src(l)) << 8) | (32'(lv_mode(l)) << 12);
  endfunction

  task automatic check_all_regs(string req);
    logic [31:0] v;
    for (int l = 0; l < NL; l++) begin
      rd('h1C + 4 * l, v); chk(req, v, cfg_rb(l));
      rd('h5C + 4 * l, v); chk(req, v, 32'(lv_m(l)));
      rd('h9C + 4 * l, v); chk(req, v, 32'(8'(~(lv_nwant(l) - lv_m(l)))));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_addr = '0; reg_wr_data = '0;
    main_cfg = 32'h0000_2315; main_m = 32'h0000_0033; main_n = 32'hFFFF_FFA0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd('h14, v); chk("R1 ctrl", v, 32'h0);
    for (int l = 0; l < NL; l++) begin
      rd('h1C + 4 * l, v); chk("R1 cfg", v, 32'h0);
      rd('h9C + 4 * l, v); chk("R1 n", v, 32'h0);
    end
    chk("R1 active", 32'(out_dfs_active), 32'h0);
    chk("R2 reset bypass", 32'(outs()), 32'(exp_main()));

    // R4 load tables with junk in unused bits, read back masked
    for (int l = 0; l < NL; l++) begin
      wr('h1C + 4 * l, cfg_rb(l) | 32'h00F0_00E0);
      wr('h5C + 4 * l, 32'(lv_m(l)) | 32'hAB00_0000);
      wr('h9C + 4 * l, 32'hFFFF_FF00 | 32'(8'(~(lv_nwant(l) - lv_m(l)))));
    end
    check_all_regs("R4 readback");

    // R2 bypass under several committed patterns, tables loaded
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      main_cfg = 32'(p * 32'h1357 + 32'h0100_0000);
      main_m   = 32'(p * 41 + 3);
      main_n   = 32'(~(p * 29 + 7));
      #1;
      chk("R2 bypass", 32'(outs()), 32'(exp_main()));
      chk("R3 inactive", 32'(out_dfs_active), 32'h0);
    end

    // R3 R5 R6 R7 R8 sweep of all 16 level codes
    for (int lv = 0; lv < 16; lv++) begin
      int el;
      el = (lv >= NL) ? NL - 1 : lv;
      wr('h14, 32'((lv << 1) | 1));
      chk("R3 R5 R6 R7 level outputs", 32'(outs()), 32'(exp_level(el)));
      chk("R3 active", 32'(out_dfs_active), 32'h1);
      rd('h14, v); chk("R7 R8 ctrl read", v, 32'((el << 1) | 1));
    end

    // R9 no change before capture edge, change right after it
    wr('h14, 32'((2 << 1) | 1));
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 8'h14; reg_wr_data = 32'((5 << 1) | 1);
    #5;
    chk("R9 before edge", 32'(outs()), 32'(exp_level(2)));
    @(negedge clk);
    reg_wr_en = 1'b0;
    chk("R9 after edge", 32'(outs()), 32'(exp_level(5)));

    // R10 unmapped writes
    wr('h00, 32'hFFFF_FFFF);
    wr('h18, 32'hFFFF_FFFF);
    wr('h1D, 32'h0000_0000);
    wr('h3C, 32'h0000_0000);
    wr('hFC, 32'h0000_0000);
    wr('h15, 32'h0000_0000);
    chk("R10 outputs", 32'(outs()), 32'(exp_level(5)));
    rd('h14, v); chk("R10 ctrl", v, 32'((5 << 1) | 1));
    check_all_regs("R10 tables");

    // R2 return to bypass after disable
    wr('h14, 32'h0000_000C);
    chk("R2 disabled again", 32'(outs()), 32'(exp_main()));
    rd('h14, v); chk("R8 disabled read", v, 32'h0000_000C);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule